// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing front end of a small serial EEPROM. It watches an open-drain two-wire bus (clock and data inputs, plus an enable that pulls the data line low), oversampling both lines with the system clock. It recognises bus start and stop conditions, takes in a control byte, acknowledges when the control byte names this device, and then moves word-address and data bytes between the bus and a byte-wide memory port.

The array size is a parameter (128, 256, 512, 1024 or 2048 bytes). It sets how the three select bits of the control byte are used. Some of them are compared with strapped address pins. The rest pick an internal 256-byte block. Written bytes go straight to the memory port. After a write transaction that carried data, the stop condition raises a one-cycle commit pulse for the page-programming sequencer. While that sequencer reports a self-timed write in progress, the controller does not answer its address.

Top module: `eeprom_bus_slave`

## Requirements
- R1: Out of reset the data line is released, and no memory write or commit pulse is issued.
- R2: Bus activity is ignored until a start condition (data falling while clock is high) is seen. A stop condition (data rising while clock is high) ends any operation and releases the data line.
- R3: The control byte is received MSB first. Its bits [7:4] must equal 4'b1010 and bit [0] is the direction (1 = read, 0 = write). On a match the data line is pulled low for the whole ninth clock; on a mismatch it stays released and the block waits for the next start.
- R4: Select bits [3:1] are compared with pins_i[2:0] only where the size leaves them as device bits. At 128/256 bytes all three are compared. At 512 bytes bits [3:2] are compared and bit [1] is address bit 8. At 1024 bytes bit [3] is compared and bits [2:1] are address bits 9:8. At 2048 bytes no bit is compared and bits [3:1] are address bits 10:8.
- R5: While wr_busy_i is high the control byte is never acknowledged and the data line stays released.
- R6: In a write, the byte after the control byte loads the low 8 bits of the address pointer, with block bits from the control byte above them. Each following byte is acknowledged and issues one mem_we_o pulse carrying that byte and the current pointer.
- R7: The pointer advances by one after every data byte written or sent, and wraps from the top of the array to address 0.
- R8: In a read, the byte at the pointer is driven MSB first. The data line changes only while the clock is low, and it is released in the master's acknowledge slot. A master acknowledge continues with the next byte. A master NACK leaves the line released until the next start or stop.
- R9: commit_o pulses for one cycle at the stop that ends a write in which at least one data byte was written. No pulse follows a read or an address-only write.
- R10: A repeated start at any point restarts control-byte reception and keeps the pointer, so that a word-address write followed by a repeated start and a read returns the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Pull the data line low when 1 |
| pins_i | input | 3 | Strapped device-select pins (unconnected = 0) |
| wr_busy_i | input | 1 | Self-timed write in progress |
| mem_addr_o | output | AW | Byte address into the array |
| mem_rdata_i | input | 8 | Read data for mem_addr_o |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | One-cycle write strobe |
| commit_o | output | 1 | One-cycle page-commit request at stop |

## Verification
The hardest point to reach is the pointer wrap at the top of the array. The default size of 512 bytes needs the block bit in the control byte together with word address 0xFF. The bench writes two bytes from there, then reads them back through a dummy write and a repeated start, so both the write path and the read path have to cross from 0x1FF to 0x000. The busy case is also reached only through a correctly framed start and a matching control byte that arrive while wr_busy_i is held high.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT_STOP
  } bus_state_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_q[SYNC_STAGES-1];
      sda_p <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_q[SYNC_STAGES-1];
  assign sda_o      = sda_q[SYNC_STAGES-1];
  assign start_o    = scl_p & scl_o & sda_p & ~sda_o;
  assign stop_o     = scl_p & scl_o & ~sda_p & sda_o;
  assign scl_rise_o = ~scl_p & scl_o;
  assign scl_fall_o = scl_p & ~scl_o;
endmodule

// File: rtl/ctrl_byte_match.sv
module ctrl_byte_match #(
  parameter int MEM_BYTES = 512,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int BLK_BITS = (AW > 8) ? AW - 8 : 0,
  localparam int BLKW = (BLK_BITS > 0) ? BLK_BITS : 1
) (
  input  logic [7:1]      ctrl_i,
  input  logic [2:0]      pins_i,
  output logic            match_o,
  output logic [BLKW-1:0] block_o
);
  import eeprom_slave_pkg::*;

  // select bits below the mask address memory blocks
  localparam logic [2:0] PIN_MASK = 3'(3'b111 << BLK_BITS);

  assign match_o = (ctrl_i[7:4] == DEV_TYPE) &&
                   (((ctrl_i[3:1] ^ pins_i) & PIN_MASK) == 3'b000);

  if (BLK_BITS > 0) begin : g_blk
    assign block_o = ctrl_i[BLK_BITS:1];
  end else begin : g_noblk
    assign block_o = 1'b0;
  end
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave #(
  parameter int MEM_BYTES = 512,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int BLKW = (AW > 8) ? AW - 8 : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  input  logic [2:0]    pins_i,
  input  logic          wr_busy_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  output logic          commit_o
);
  import eeprom_slave_pkg::*;

  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic dev_match;
  logic [BLKW-1:0] blk_sel, blk_q;
  logic [AW-1:0] load_addr, ptr_q;
  bus_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic rw_q, mack_q, dirty_q, commit_q;
  logic byte_done;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  ctrl_byte_match #(.MEM_BYTES(MEM_BYTES)) u_match (
    .ctrl_i(sh_q[7:1]), .pins_i(pins_i), .match_o(dev_match), .block_o(blk_sel)
  );

  if (AW > 8) begin : g_wide
    assign load_addr = {blk_q, sh_q};
  end else begin : g_narrow
    assign load_addr = sh_q[AW-1:0];
  end

  assign byte_done = scl_fall && (cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      blk_q    <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      dirty_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (start_det) begin
        state_q <= ST_CTRL;
        cnt_q   <= '0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        commit_q <= dirty_q;
        dirty_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_CTRL, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end
            if (byte_done) begin
              if (state_q == ST_CTRL) begin
                if (dev_match && !wr_busy_i) begin
                  state_q <= ST_CTRL_ACK;
                  rw_q    <= sh_q[0];
                  blk_q   <= blk_sel;
                  dirty_q <= 1'b0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADDR) begin
                state_q <= ST_WADDR_ACK;
              end else begin
                state_q <= ST_WDATA_ACK;
                ptr_q   <= ptr_q + 1'b1;
                dirty_q <= 1'b1;
              end
            end
          end
          ST_CTRL_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RDATA;
              sh_q    <= mem_rdata_i;
            end else begin
              state_q <= ST_WADDR;
            end
          end
          ST_WADDR_ACK: if (scl_fall) begin
            ptr_q   <= load_addr;
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall) begin
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise) cnt_q <= cnt_q + 4'd1;
            if (byte_done) begin
              state_q <= ST_RACK;
              ptr_q   <= ptr_q + 1'b1;
            end else if (scl_fall) begin
              sh_q <= {sh_q[6:0], 1'b0};
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                state_q <= ST_RDATA;
                sh_q    <= mem_rdata_i;
              end else begin
                state_q <= ST_WAIT_STOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
      ST_RDATA:                                sda_pull_o = ~sh_q[7];
      default:                                 sda_pull_o = 1'b0;
    endcase
  end

  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = sh_q;
  assign mem_we_o    = (state_q == ST_WDATA) && byte_done && !start_det && !stop_det;
  assign commit_o    = commit_q;
endmodule

// File: rtl/eeprom_bus_slave_chk.sv
module eeprom_bus_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic wr_busy_i,
  input logic sda_pull_o,
  input logic mem_we_o,
  input logic commit_o,
  input eeprom_slave_pkg::bus_state_e state_q
);
  import eeprom_slave_pkg::*;

  AST_RESET_QUIET: assert property (@(posedge clk_i) $rose(rst_ni) |-> !sda_pull_o && !mem_we_o && !commit_o); // R1
  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_pull_o); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o); // R2
  AST_BUSY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CTRL_ACK && $past(state_q) != ST_CTRL_ACK) |-> !$past(wr_busy_i)); // R5
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R6
  AST_WE_THEN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sda_pull_o); // R6
  AST_PULL_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_s); // R8
  AST_PULL_FALL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_o) |-> !scl_s); // R8
  AST_COMMIT_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_det)); // R9
endmodule

bind eeprom_bus_slave eeprom_bus_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .wr_busy_i(wr_busy_i), .sda_pull_o(sda_pull_o),
  .mem_we_o(mem_we_o), .commit_o(commit_o), .state_q(state_q)
);

// File: tb/eeprom_bus_slave_test.sv
module eeprom_bus_slave_test;
  localparam int MEM_BYTES = 512;
  localparam int AW = $clog2(MEM_BYTES);
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b010;
  logic wr_busy = 1'b0;
  logic sda_pull, mem_we, commit;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem [MEM_BYTES];
  wire sda_line = sda_m & ~sda_pull;
  int checks = 0, errors = 0, commits = 0, writes = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eeprom_bus_slave #(.MEM_BYTES(MEM_BYTES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .pins_i(pins), .wr_busy_i(wr_busy),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem[mem_addr]), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .commit_o(commit)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      writes <= writes + 1;
    end
    if (commit) commits <= commits + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wq();
    scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      b[i] = sda_line; wq();
      scl_m = 1'b0; wq();
    end
    sda_m = ~ack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic t_reset();
    chk("R1 pull", sda_pull, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 commit", commit, 0);
  endtask

  task automatic t_no_start();
    logic a;
    send_byte(8'hA4, a);
    chk("R2 no ack without start", a, 0);
    bus_stop();
  endtask

  task automatic t_bad_ctrl();
    logic a;
    bus_start(); send_byte(8'hB4, a);
    chk("R3 wrong type nack", a, 0);
    bus_stop();
    bus_start(); send_byte(8'hA0, a);
    chk("R4 wrong pins nack", a, 0);
    bus_stop();
    pins = 3'b011;
    bus_start(); send_byte(8'hA4, a);
    chk("R4 pin0 not compared", a, 1);
    bus_stop();
    pins = 3'b010;
    chk("R9 no commit after address-only", commits, 0);
  endtask

  task automatic t_write();
    logic a;
    int w0 = writes;
    bus_start(); send_byte(8'hA4, a);
    chk("R3 ctrl ack", a, 1);
    send_byte(8'h10, a); chk("R6 word ack", a, 1);
    send_byte(8'h3C, a); chk("R6 data ack", a, 1);
    send_byte(8'hC3, a); chk("R6 data ack 2", a, 1);
    bus_stop(); wq();
    chk("R6 mem 0x010", mem[9'h010], 8'h3C);
    chk("R7 mem 0x011", mem[9'h011], 8'hC3);
    chk("R6 write count", writes - w0, 2);
    chk("R9 commit after write", commits, 1);
  endtask

  task automatic t_block();
    logic a;
    bus_start(); send_byte(8'hA6, a); send_byte(8'h20, a); send_byte(8'h77, a);
    bus_stop(); wq();
    chk("R4 block bit selects 0x120", mem[9'h120], 8'h77);
    chk("R4 block 0 untouched", mem[9'h020], 8'h20 ^ 8'h5A);
  endtask

  task automatic t_wrap_write();
    logic a;
    bus_start(); send_byte(8'hA6, a); send_byte(8'hFF, a);
    send_byte(8'h11, a); send_byte(8'h22, a);
    bus_stop(); wq();
    chk("R7 top byte", mem[9'h1FF], 8'h11);
    chk("R7 wrapped to 0", mem[9'h000], 8'h22);
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] d;
    int c0 = commits;
    bus_start(); send_byte(8'hA4, a); send_byte(8'h10, a);
    bus_start(); send_byte(8'hA5, a);
    chk("R10 read ctrl ack after repeated start", a, 1);
    recv_byte(d, 1'b1); chk("R8 first byte", d, 8'h3C);
    recv_byte(d, 1'b0); chk("R8 second byte", d, 8'hC3);
    wq();
    chk("R8 released after nack", sda_pull, 0);
    scl_m = 1'b1; wq();
    chk("R8 still released in clock high", sda_pull, 0);
    scl_m = 1'b0; wq();
    bus_stop(); wq();
    chk("R9 no commit after read", commits - c0, 0);
  endtask

  task automatic t_wrap_read();
    logic a;
    logic [7:0] d;
    bus_start(); send_byte(8'hA6, a); send_byte(8'hFF, a);
    bus_start(); send_byte(8'hA5, a);
    recv_byte(d, 1'b1); chk("R7 read top", d, 8'h11);
    recv_byte(d, 1'b0); chk("R7 read wrapped", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_busy();
    logic a;
    int w0 = writes;
    wr_busy = 1'b1;
    bus_start(); send_byte(8'hA4, a);
    chk("R5 no ack while busy", a, 0);
    send_byte(8'h30, a);
    chk("R5 stays silent", a, 0);
    bus_stop();
    wr_busy = 1'b0; wq();
    chk("R5 no write while busy", writes - w0, 0);
    bus_start(); send_byte(8'hA4, a);
    chk("R5 ack once idle", a, 1);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wq();
    t_reset();
    t_no_start();
    t_bad_ctrl();
    t_write();
    t_block();
    t_wrap_write();
    t_random_read();
    t_wrap_read();
    t_busy();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule